// File: doc/BRIEF.md
# Line Latch and Output State Sequencer

This block sits between the display-data register of a column driver and its analog output stage. Once per horizontal line a strobe pulse arrives. The rising edge of the strobe copies the whole data register into a line latch, and a polarity bit is captured at the same moment. The falling edge of the strobe releases the outputs, which then drive from the latched gray-scale codes.

The polarity bit picks which half of the reference ladder each output uses. Outputs are numbered from 1, so odd outputs occupy vector bits 0, 2, 4 and so on. While the strobe is high, every output is either pulled to reset or left floating. It is reset when the captured polarity differs from the previous line's, and floating when it is the same.

The strobe is sampled on the system clock, so its edges are found synchronously. The analog converters, slew control and output-resistance control are outside this block.

Top module: `line_latch_ctl`

## Requirements
- R1: While `rst_n` is low, on each clock edge `lat_q` becomes all zeros, `st_code` becomes 2'b10 (high impedance), and the held polarity becomes low. With polarity low, `rng_hi` has its even-indexed bits at 1 and its odd-indexed bits at 0.
- R2: On the clock edge where `stb` is sampled high after being sampled low on the previous edge (a detected rising edge), `lat_q` takes the value of `din` from that edge.
- R3: On a detected rising edge the polarity `pol` is captured. After that edge, `rng_hi[i]` is `~pol` for even i (odd outputs) and `pol` for odd i (even outputs), where 1 selects the upper reference range.
- R4: If the polarity captured on a detected rising edge differs from the previously held polarity, `st_code` becomes 2'b01 (reset) after that edge.
- R5: If the polarity captured on a detected rising edge equals the previously held polarity, `st_code` becomes 2'b10 (high impedance) after that edge.
- R6: On the clock edge where `stb` is sampled low after being sampled high (a detected falling edge), `st_code` becomes 2'b00 (drive).
- R7: On edges with no detected strobe edge, `lat_q`, `st_code` and `rng_hi` keep their values. Changes of `din` or `pol` in that time have no effect.
- R8: The first line after reset compares its polarity against low. A high polarity on the first rising edge gives reset (2'b01), and `st_code` stays 2'b10 from reset until the first detected falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb | input | 1 | Line strobe, sampled on `clk` |
| pol | input | 1 | Polarity select, captured on strobe rise |
| din | input | NUM_OUT*DW | Filled data register, output 1 in the low DW bits |
| lat_q | output | NUM_OUT*DW | Line latch contents |
| rng_hi | output | NUM_OUT | Per-output reference range, 1 = upper |
| st_code | output | 2 | Output state: 00 drive, 01 reset, 10 high impedance |

## Verification
The two functions that can land on neighbouring or coinciding edges are the rise handling and the fall handling. The rise copies data, captures polarity and chooses reset or high impedance. The fall returns the outputs to drive. The bench provokes this with single-clock strobe pulses, where the fall is detected on the very next edge. It also flips `pol` and `din` on the same edge as the rise, and again while the strobe is held high. A behavioural reference model is compared on every clock. It judges whether the rise decision was taken against the previous line's polarity, and whether later input changes stay invisible.

// File: rtl/line_latch_pkg.sv
// Package: shared encoding of the output state code.
// Assumes: the analog stage decodes 00 as drive, 01 as reset, 10 as high impedance.
package line_latch_pkg;
    typedef enum logic [1:0] {
        OST_DRIVE = 2'b00,
        OST_RESET = 2'b01,
        OST_HIZ   = 2'b10
    } ost_t;
endpackage

// File: rtl/stb_edge_det.sv
// Module: finds rising and falling edges of the strobe by sampling on clk.
// Assumes: stb is already synchronous to clk; the sampled copy resets low.
module stb_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic rise,
    output logic fall
);
    logic stb_d;

    // Hold the strobe level seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= stb;
    end

    // Compare the current level with the held one.
    always_comb begin
        rise = stb & ~stb_d;
        fall = ~stb & stb_d;
    end
endmodule

// File: rtl/line_store.sv
// Module: line latch, loads the whole data register on a detected strobe rise.
// Assumes: din is stable on the edge where the rise is detected.
module line_store #(
    parameter int W = 3072
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Capture on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/ost_seq.sv
// Module: holds the line polarity and sequences the output state code.
// Assumes: one rise and one fall per line; the held polarity resets low.
module ost_seq
    import line_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       fall,
    input  logic       pol,
    output logic       pol_q,
    output logic [1:0] st
);
    ost_t st_r;
    logic flip;

    // A polarity flip is judged against the previous line's value.
    always_comb flip = (pol != pol_q);

    // Capture the polarity on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n)    pol_q <= 1'b0;
        else if (rise) pol_q <= pol;
    end

    // Rise picks reset or floating; fall returns to drive.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_r <= OST_HIZ;
        else if (rise)   st_r <= flip ? OST_RESET : OST_HIZ;
        else if (fall)   st_r <= OST_DRIVE;
    end

    // Present the state as a plain code.
    always_comb st = st_r;
endmodule

// File: rtl/range_map.sv
// Module: maps the line polarity onto a per-output reference range bit.
// Assumes: bit 0 is output 1 (odd); 1 selects the upper range.
module range_map #(
    parameter int NUM_OUT = 384
) (
    input  logic               pol_q,
    output logic [NUM_OUT-1:0] rng_hi
);
    // Alternate the range across odd and even outputs.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        if ((i % 2) == 0) begin : g_odd
            assign rng_hi[i] = ~pol_q;
        end else begin : g_even
            assign rng_hi[i] = pol_q;
        end
    end
endmodule

// File: rtl/line_latch_ctl.sv
// Module: top of the line latch and output state control.
// Assumes: one strobe pulse per line, at least one clock high and one low.
module line_latch_ctl #(
    parameter int NUM_OUT = 384,
    parameter int DW      = 8,
    localparam int W      = NUM_OUT * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb,
    input  logic               pol,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       lat_q,
    output logic [NUM_OUT-1:0] rng_hi,
    output logic [1:0]         st_code
);
    logic rise, fall, pol_q;

    stb_edge_det u_edge (.clk(clk), .rst_n(rst_n), .stb(stb), .rise(rise), .fall(fall));

    line_store #(.W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(rise), .din(din), .q(lat_q)
    );

    ost_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .pol(pol), .pol_q(pol_q), .st(st_code)
    );

    range_map #(.NUM_OUT(NUM_OUT)) u_map (.pol_q(pol_q), .rng_hi(rng_hi));
endmodule

// File: rtl/line_latch_ctl_chk.sv
// Module: property checker bound into the top.
// Assumes: the internal edge strobes and held polarity are visible by name.
module line_latch_ctl_chk #(
    parameter int NUM_OUT = 384,
    parameter int W       = 3072
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rise,
    input logic               fall,
    input logic               pol,
    input logic               pol_q,
    input logic [W-1:0]       din,
    input logic [W-1:0]       lat_q,
    input logic [NUM_OUT-1:0] rng_hi,
    input logic [1:0]         st_code
);
    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> lat_q == $past(din));

    assert_flip_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && pol != pol_q) |=> st_code == 2'b01);

    assert_same_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && pol == pol_q) |=> st_code == 2'b10);

    assert_fall_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rise) |=> st_code == 2'b00);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !fall) |=> ($stable(st_code) && $stable(lat_q) && $stable(rng_hi)));

    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rng_hi[0] == ~pol_q && rng_hi[NUM_OUT-1] == ((NUM_OUT % 2 == 0) ? pol_q : ~pol_q));

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_code != 2'b11);
endmodule

bind line_latch_ctl line_latch_ctl_chk #(.NUM_OUT(NUM_OUT), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .pol(pol),
    .pol_q(pol_q), .din(din), .lat_q(lat_q), .rng_hi(rng_hi), .st_code(st_code)
);

// File: tb/sim_line_latch_ctl.sv
module sim_line_latch_ctl;
    localparam int NUM_OUT = 384;
    localparam int DW      = 8;
    localparam int W       = NUM_OUT * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic pol = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] lat_q;
    logic [NUM_OUT-1:0] rng_hi;
    logic [1:0] st_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    line_latch_ctl #(.NUM_OUT(NUM_OUT), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .stb(stb), .pol(pol), .din(din),
        .lat_q(lat_q), .rng_hi(rng_hi), .st_code(st_code)
    );

    // Behavioural reference model
    logic [W-1:0] m_lat;
    logic m_pol, m_sd, m_first;
    logic [1:0] m_st;
    string m_tag;

    function automatic logic [NUM_OUT-1:0] exp_rng(input logic p);
        logic [NUM_OUT-1:0] r;
        for (int i = 0; i < NUM_OUT; i++) r[i] = (i % 2 == 0) ? ~p : p;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = '0; m_pol = 0; m_sd = 0; m_st = 2'b10; m_first = 1; m_tag = "R1";
        end else begin
            if (stb && !m_sd) begin
                m_lat = din;
                if (pol != m_pol) begin m_st = 2'b01; m_tag = m_first ? "R8" : "R4"; end
                else              begin m_st = 2'b10; m_tag = m_first ? "R8" : "R5"; end
                m_pol = pol;
                m_first = 0;
            end else if (!stb && m_sd) begin
                m_st = 2'b00; m_tag = "R6";
            end else begin
                m_tag = "R7";
            end
            m_sd = stb;
        end
    end

    // Compare every clock, shortly after the edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            n_run++;
            if (st_code !== m_st) begin
                n_fail++;
                $display("FAIL %s st_code actual=%b expected=%b", m_tag, st_code, m_st);
            end
            n_run++;
            if (lat_q !== m_lat) begin
                n_fail++;
                $display("FAIL R2 lat_q low word actual=%h expected=%h", lat_q[31:0], m_lat[31:0]);
            end
            n_run++;
            if (rng_hi !== exp_rng(m_pol)) begin
                n_fail++;
                $display("FAIL R3 rng_hi low bits actual=%b expected=%b", rng_hi[3:0], exp_rng(m_pol) & 4'hf);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic new_data();
        for (int i = 0; i < W / 32; i++) din[i*32 +: 32] = $urandom;
    endtask

    // One line: data and polarity set up before rise, strobe high for hi clocks.
    task automatic line(input logic p, input int hi, input int lo);
        new_data();
        pol = p;
        @(negedge clk) stb = 1;
        tick(hi);
        stb = 0;
        tick(lo);
    endtask

    task automatic named(input string tag, input bit ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        tick(3);
        // R1: reset values
        named("R1", st_code == 2'b10 && lat_q == '0 && rng_hi[1:0] == 2'b01, st_code, 2);
        rst_n = 1;
        tick(4);
        named("R8", st_code == 2'b10, st_code, 2);
        // R8: first line with high polarity gives reset
        new_data(); pol = 1;
        @(negedge clk) stb = 1;
        @(negedge clk);
        named("R8", st_code == 2'b01, st_code, 1);
        // R7: polarity and data change while strobe high
        pol = 0; new_data();
        tick(3);
        named("R7", st_code == 2'b01 && rng_hi[0] == 1'b0, st_code, 1);
        stb = 0;
        @(negedge clk);
        named("R6", st_code == 2'b00, st_code, 0);
        tick(3);
        // R5: same polarity gives high impedance
        line(1, 2, 4);
        // R4: flips, including one-clock strobe pulses
        line(0, 1, 3);
        line(1, 1, 1);
        line(1, 1, 2);
        line(0, 5, 2);
        for (int k = 0; k < 40; k++) line($urandom % 2, 1 + $urandom % 4, 1 + $urandom % 4);
        // Data change on the same edge as rise is taken
        pol = 0; new_data();
        @(negedge clk) begin stb = 1; end
        tick(2);
        stb = 0; tick(3);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule